// File: doc/BRIEF.md
# Serial Character Receiver with Address-Filter Mode

This block receives asynchronous serial characters on a single input line. An external tick at sixteen times the bit rate paces it. The line passes through a synchronizer. A falling edge that is still low half a bit later starts a character. Each later bit is taken at its centre, least significant bit first. A character has 7, 8 or 9 data bits. In the 7- and 8-bit formats a parity bit may follow the data. The character ends with a single stop bit.

Each completed character goes into a one-entry receive buffer and sets a buffer-full flag. Software empties the buffer with a read strobe. Parity, framing and overrun errors are held in flags until software pulses the status-read strobe. A line-low flag reports a line held low after a framing error. A receive interrupt is raised while the buffer is full and the interrupt enable is set.

An attention mode supports multiprocessor links. While it is active in the 9-bit format, the block drops every character whose ninth bit is 0. The first character whose ninth bit is 1 is accepted, and that character ends the mode.

The frame state machine has six states:
- ST_IDLE: waits for a tick with the line low.
- ST_START: confirms the start bit at the half-bit sample.
- ST_DATA: shifts in the data bits.
- ST_PARITY: takes the parity bit.
- ST_STOP: checks the stop bit.
- ST_BREAK: waits for the line to go high after a framing error.

The transitions are:
- ST_IDLE→ST_START: on a low tick.
- ST_START→ST_IDLE: the half-bit sample is high.
- ST_START→ST_DATA: the half-bit sample is low.
- ST_DATA→ST_PARITY: after the last data bit, when parity is active.
- ST_DATA→ST_STOP: after the last data bit, when parity is not active.
- ST_PARITY→ST_STOP: after the parity bit is taken.
- ST_STOP→ST_IDLE: the stop bit is high.
- ST_STOP→ST_BREAK: the stop bit is low.
- ST_BREAK→ST_IDLE: the line is high.

Top module: `uart_attn_rx`

## Requirements
- R1: After reset, every output is 0: the data, the ninth bit, buffer-full, all three error flags, the global error, line-low, attention and the interrupt.
- R2: A character has a low start bit, data bits sent least significant bit first, and a high stop bit. Once received, its data appears on data_o and full_o sets. A one-cycle rd_buf_i pulse clears full_o.
- R3: With frm_len_i=2'b01, seven data bits are received and data_o[7] reads 0.
- R4: With frm_len_i=2'b10 or 2'b11, nine data bits are received. The ninth bit appears on bit9_o.
- R5: par_en_i=1 in the 7- or 8-bit format adds a parity bit after the data. par_sel_i selects the expected value: 00 odd, 01 even, 10 always 1, 11 always 0. A mismatch sets pe_o. In the 9-bit format no parity bit is expected and pe_o is unaffected.
- R6: A low stop bit sets fe_o and line_low_o, and the character is still buffered. Until the line goes high, no new character starts. line_low_o clears once the line is high again.
- R7: A character that completes while full_o is set, with no buffer read in that cycle, sets ovr_o. data_o keeps the earlier character.
- R8: pe_o, fe_o and ovr_o stay set until a rd_stat_i pulse clears them. err_o is 1 exactly when at least one of them is 1.
- R9: attn_set_i enters attention mode (attn_o=1). In the 9-bit format, characters with ninth bit 0 are then dropped and full_o stays 0. A character with ninth bit 1 is buffered and clears attn_o.
- R10: irq_o is 1 exactly when full_o and rx_ie_i are both 1.
- R11: A low pulse shorter than half a bit time does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| frm_len_i | input | 2 | Format: 00 eight, 01 seven, 1x nine data bits |
| par_en_i | input | 1 | Parity enable (7/8-bit formats) |
| par_sel_i | input | 2 | Parity kind: odd, even, one, zero |
| rx_ie_i | input | 1 | Receive interrupt enable |
| attn_set_i | input | 1 | Pulse to enter attention mode |
| rd_buf_i | input | 1 | Receive buffer read strobe |
| rd_stat_i | input | 1 | Status read strobe, clears error flags |
| data_o | output | 8 | Received data bits 0..7 |
| bit9_o | output | 1 | Received ninth bit |
| full_o | output | 1 | Buffer holds an unread character |
| pe_o | output | 1 | Parity error |
| fe_o | output | 1 | Framing error |
| ovr_o | output | 1 | Overrun error |
| err_o | output | 1 | Any error flag set |
| line_low_o | output | 1 | Line held low after framing error |
| attn_o | output | 1 | Attention mode active |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench builds the block with its defaults: 16 ticks per bit and a two-stage synchronizer. It issues a tick every fourth clock, so one bit lasts 64 clocks. At that spacing the half-bit confirmation, the centre sampling and the synchronizer delay all fit well inside a bit. Glitches a few ticks long, held breaks and back-to-back characters can then be timed exactly from the bench. This also lets every format, parity kind and attention case run within a few dozen frames.

// File: rtl/uart_attn_rx_pkg.sv
package uart_attn_rx_pkg;

    localparam int CHAR_BITS = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ONE   = 2'b10,
        PAR_ZERO  = 2'b11
    } par_sel_t;

    typedef struct packed {
        logic [CHAR_BITS-1:0] bits;
        logic                 par_bad;
        logic                 frm_bad;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    localparam int N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= {N{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[N-2:0], d_i};
        end
    end

    assign q_o = chain_q[N-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_attn_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       line_i,
    input  logic [1:0] frm_len_i,
    input  logic       par_en_i,
    input  logic [1:0] par_sel_i,
    output logic       done_o,
    output rx_char_t   char_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(CHAR_BITS + 1);
    localparam logic [CNT_W-1:0] MID_CNT = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] END_CNT = CNT_W'(OVS - 1);

    rx_state_t            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [IDX_W-1:0]     last_idx;
    logic [CHAR_BITS-1:0] shift_q;
    logic [CHAR_BITS-1:0] par_mask;
    logic                 par_bit_q;
    logic                 par_on;
    logic                 at_point;
    logic                 sample;
    logic                 data_x;
    logic                 par_bad;
    logic                 done_q;
    rx_char_t             char_q;

    // format decode
    always_comb begin
        unique case (frm_len_i)
            2'b00:   last_idx = IDX_W'(7);
            2'b01:   last_idx = IDX_W'(6);
            default: last_idx = IDX_W'(8);
        endcase
    end

    assign par_on   = par_en_i && !frm_len_i[1];
    assign at_point = (state_q == ST_START) ? (cnt_q == MID_CNT) : (cnt_q == END_CNT);
    assign sample   = tick_i && at_point;

    // parity evaluation over the data bits of the current format
    assign par_mask = (frm_len_i == 2'b01) ? CHAR_BITS'(9'h07F) : CHAR_BITS'(9'h0FF);
    assign data_x   = ^(shift_q & par_mask);

    always_comb begin
        unique case (par_sel_t'(par_sel_i))
            PAR_ODD:  par_bad = par_on && ((data_x ^ par_bit_q) != 1'b1);
            PAR_EVEN: par_bad = par_on && ((data_x ^ par_bit_q) != 1'b0);
            PAR_ONE:  par_bad = par_on && !par_bit_q;
            PAR_ZERO: par_bad = par_on && par_bit_q;
            default:  par_bad = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (tick_i && !line_i) state_d = ST_START;
            end
            ST_START: begin
                if (sample) state_d = line_i ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (sample && (idx_q == last_idx)) state_d = par_on ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: begin
                if (sample) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (sample) state_d = line_i ? ST_IDLE : ST_BREAK;
            end
            ST_BREAK: begin
                if (line_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shift_q   <= '0;
            par_bit_q <= 1'b0;
            done_q    <= 1'b0;
            char_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE || state_q == ST_BREAK) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                cnt_q <= sample ? '0 : cnt_q + 1'b1;
            end
            if (state_q == ST_IDLE) begin
                idx_q     <= '0;
                shift_q   <= '0;
                par_bit_q <= 1'b0;
            end
            if (state_q == ST_DATA && sample) begin
                shift_q[idx_q] <= line_i;
                idx_q          <= idx_q + 1'b1;
            end
            if (state_q == ST_PARITY && sample) begin
                par_bit_q <= line_i;
            end
            if (state_q == ST_STOP && sample) begin
                done_q         <= 1'b1;
                char_q.bits    <= shift_q;
                char_q.par_bad <= par_bad;
                char_q.frm_bad <= !line_i;
            end
        end
    end

    assign done_o = done_q;
    assign char_o = char_q;
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_attn_rx_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       done_i,
    input  rx_char_t   char_i,
    input  logic       nine_i,
    input  logic       line_i,
    input  logic       attn_set_i,
    input  logic       rd_buf_i,
    input  logic       rd_stat_i,
    input  logic       rx_ie_i,
    output logic [7:0] data_o,
    output logic       bit9_o,
    output logic       full_o,
    output logic       pe_o,
    output logic       fe_o,
    output logic       ovr_o,
    output logic       err_o,
    output logic       line_low_o,
    output logic       attn_o,
    output logic       irq_o
);
    logic [7:0] data_q;
    logic       bit9_q, full_q, pe_q, fe_q, ovr_q, low_q, attn_q;
    logic       dropped, accept, still_full, load, overrun;

    assign dropped    = attn_q && nine_i && !char_i.bits[CHAR_BITS-1];
    assign accept     = done_i && !dropped;
    assign still_full = full_q && !rd_buf_i;
    assign load       = accept && !still_full;
    assign overrun    = accept && still_full;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            data_q <= '0;
            bit9_q <= 1'b0;
            full_q <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            ovr_q  <= 1'b0;
            low_q  <= 1'b0;
            attn_q <= 1'b0;
        end else begin
            if (load) begin
                data_q <= char_i.bits[7:0];
                bit9_q <= nine_i && char_i.bits[CHAR_BITS-1];
            end
            if (load)          full_q <= 1'b1;
            else if (rd_buf_i) full_q <= 1'b0;

            if (accept && char_i.par_bad) pe_q <= 1'b1;
            else if (rd_stat_i)           pe_q <= 1'b0;

            if (accept && char_i.frm_bad) fe_q <= 1'b1;
            else if (rd_stat_i)           fe_q <= 1'b0;

            if (overrun)        ovr_q <= 1'b1;
            else if (rd_stat_i) ovr_q <= 1'b0;

            if (done_i && char_i.frm_bad) low_q <= 1'b1;
            else if (line_i)              low_q <= 1'b0;

            if (attn_set_i)                                             attn_q <= 1'b1;
            else if (accept && nine_i && char_i.bits[CHAR_BITS-1])      attn_q <= 1'b0;
        end
    end

    assign data_o     = data_q;
    assign bit9_o     = bit9_q;
    assign full_o     = full_q;
    assign pe_o       = pe_q;
    assign fe_o       = fe_q;
    assign ovr_o      = ovr_q;
    assign err_o      = pe_q | fe_q | ovr_q;
    assign line_low_o = low_q;
    assign attn_o     = attn_q;
    assign irq_o      = full_q & rx_ie_i;
endmodule

// File: rtl/uart_attn_rx.sv
module uart_attn_rx
    import uart_attn_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic [1:0] frm_len_i,
    input  logic       par_en_i,
    input  logic [1:0] par_sel_i,
    input  logic       rx_ie_i,
    input  logic       attn_set_i,
    input  logic       rd_buf_i,
    input  logic       rd_stat_i,
    output logic [7:0] data_o,
    output logic       bit9_o,
    output logic       full_o,
    output logic       pe_o,
    output logic       fe_o,
    output logic       ovr_o,
    output logic       err_o,
    output logic       line_low_o,
    output logic       attn_o,
    output logic       irq_o
);
    logic     line_s;
    logic     rx_done;
    rx_char_t rx_char;

    uart_rx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rx_i),
        .q_o    (line_s)
    );

    uart_rx_frame #(.OVS(OVS)) u_frame (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .line_i    (line_s),
        .frm_len_i (frm_len_i),
        .par_en_i  (par_en_i),
        .par_sel_i (par_sel_i),
        .done_o    (rx_done),
        .char_o    (rx_char)
    );

    uart_rx_status u_status (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .done_i     (rx_done),
        .char_i     (rx_char),
        .nine_i     (frm_len_i[1]),
        .line_i     (line_s),
        .attn_set_i (attn_set_i),
        .rd_buf_i   (rd_buf_i),
        .rd_stat_i  (rd_stat_i),
        .rx_ie_i    (rx_ie_i),
        .data_o     (data_o),
        .bit9_o     (bit9_o),
        .full_o     (full_o),
        .pe_o       (pe_o),
        .fe_o       (fe_o),
        .ovr_o      (ovr_o),
        .err_o      (err_o),
        .line_low_o (line_low_o),
        .attn_o     (attn_o),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/uart_attn_rx_chk.sv
module uart_attn_rx_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       rd_buf_i,
    input logic       rd_stat_i,
    input logic       rx_done,
    input logic       line_s,
    input logic       full_o,
    input logic       pe_o,
    input logic       fe_o,
    input logic       ovr_o,
    input logic       line_low_o,
    input logic       attn_o,
    input logic [7:0] data_o
);
    p_buf_read_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_buf_i && !rx_done) |=> !full_o);

    p_full_from_char_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(full_o) |-> $past(rx_done));

    p_old_data_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && !rd_buf_i) |=> $stable(data_o));

    p_pe_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pe_o && !rd_stat_i) |=> pe_o);

    p_fe_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fe_o && !rd_stat_i) |=> fe_o);

    p_status_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stat_i && !rx_done) |=> !(pe_o || fe_o || ovr_o));

    p_line_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (line_s && !rx_done) |=> !line_low_o);

    p_attn_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(attn_o) |-> $past(rx_done));
endmodule

bind uart_attn_rx uart_attn_rx_chk u_chk (.*);

// File: tb/uart_attn_rx_bench.sv
module uart_attn_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick;
    logic [1:0] frm_len = 2'b00;
    logic       par_en = 1'b0;
    logic [1:0] par_sel = 2'b00;
    logic       rx_ie = 1'b0;
    logic       attn_set = 1'b0;
    logic       rd_buf = 1'b0;
    logic       rd_stat = 1'b0;
    logic [7:0] data;
    logic       bit9, full, pe, fe, ovr, err, line_low, attn, irq;
    logic [1:0] tdiv;
    int         total = 0;
    int         bad = 0;

    always #4 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tdiv <= '0;
        else        tdiv <= tdiv + 1'b1;
    end
    assign tick = (tdiv == 2'd3);

    uart_attn_rx u_uart_attn_rx (
        .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick_i(tick),
        .frm_len_i(frm_len), .par_en_i(par_en), .par_sel_i(par_sel),
        .rx_ie_i(rx_ie), .attn_set_i(attn_set), .rd_buf_i(rd_buf), .rd_stat_i(rd_stat),
        .data_o(data), .bit9_o(bit9), .full_o(full), .pe_o(pe), .fe_o(fe),
        .ovr_o(ovr), .err_o(err), .line_low_o(line_low), .attn_o(attn), .irq_o(irq)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        @(negedge clk) rx = v;
        repeat (63) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] d, input int nb, input bit use_par, input logic pb, input logic stopv);
        bit_time(1'b0);
        for (int i = 0; i < nb; i++) bit_time(d[i]);
        if (use_par) bit_time(pb);
        bit_time(stopv);
        repeat (8) @(negedge clk);
    endtask

    task automatic pulse_rd_buf();
        @(negedge clk) rd_buf = 1'b1;
        @(negedge clk) rd_buf = 1'b0;
    endtask

    task automatic pulse_rd_stat();
        @(negedge clk) rd_stat = 1'b1;
        @(negedge clk) rd_stat = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "data", 16'(data), 16'h0);
        chk("R1", "flags", 16'({bit9, full, pe, fe, ovr, err, line_low, attn, irq}), 16'h0);
    endtask

    task automatic t_eight();
        frm_len = 2'b00; rx_ie = 1'b1;
        send(9'h0A5, 8, 0, 1'b0, 1'b1);
        chk("R2", "full", 16'(full), 16'h1);
        chk("R2", "data", 16'(data), 16'h00A5);
        chk("R10", "irq enabled", 16'(irq), 16'h1);
        @(negedge clk) rx_ie = 1'b0;
        @(negedge clk);
        chk("R10", "irq disabled", 16'(irq), 16'h0);
        rx_ie = 1'b1;
        pulse_rd_buf();
        chk("R2", "full after read", 16'(full), 16'h0);
        chk("R10", "irq after read", 16'(irq), 16'h0);
        rx_ie = 1'b0;
    endtask

    task automatic t_seven();
        frm_len = 2'b01;
        send(9'h06B, 7, 0, 1'b0, 1'b1);
        chk("R3", "seven-bit data", 16'(data), 16'h006B);
        chk("R3", "full", 16'(full), 16'h1);
        pulse_rd_buf();
    endtask

    task automatic t_nine();
        frm_len = 2'b10;
        send(9'h1C3, 9, 0, 1'b0, 1'b1);
        chk("R4", "data", 16'(data), 16'h00C3);
        chk("R4", "ninth bit 1", 16'(bit9), 16'h1);
        pulse_rd_buf();
        frm_len = 2'b11;
        send(9'h03C, 9, 0, 1'b0, 1'b1);
        chk("R4", "data fmt11", 16'(data), 16'h003C);
        chk("R4", "ninth bit 0", 16'(bit9), 16'h0);
        pulse_rd_buf();
    endtask

    task automatic t_parity();
        logic [7:0] d;
        logic       good;
        frm_len = 2'b00; par_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            par_sel = 2'(s);
            d = 8'h35 + 8'(s * 17);
            case (s)
                0: good = ~^d;
                1: good = ^d;
                2: good = 1'b1;
                default: good = 1'b0;
            endcase
            send({1'b0, d}, 8, 1, good, 1'b1);
            chk("R5", "good parity no error", 16'(pe), 16'h0);
            chk("R5", "data with parity", 16'(data), 16'(d));
            pulse_rd_buf();
            send({1'b0, d}, 8, 1, ~good, 1'b1);
            chk("R5", "bad parity flagged", 16'(pe), 16'h1);
            chk("R8", "err follows pe", 16'(err), 16'h1);
            pulse_rd_stat();
            chk("R8", "pe cleared by status read", 16'(pe), 16'h0);
            chk("R8", "err cleared", 16'(err), 16'h0);
            pulse_rd_buf();
        end
        frm_len = 2'b10;
        send(9'h0F0, 9, 0, 1'b0, 1'b1);
        chk("R5", "nine-bit ignores parity enable", 16'(pe), 16'h0);
        chk("R5", "nine-bit data", 16'(data), 16'h00F0);
        pulse_rd_buf();
        par_en = 1'b0; par_sel = 2'b00;
    endtask

    task automatic t_framing();
        frm_len = 2'b00;
        send(9'h03C, 8, 0, 1'b0, 1'b0);
        repeat (32) @(negedge clk);
        chk("R6", "fe set", 16'(fe), 16'h1);
        chk("R6", "line low set", 16'(line_low), 16'h1);
        chk("R6", "char buffered", 16'(data), 16'h003C);
        chk("R8", "err from fe", 16'(err), 16'h1);
        pulse_rd_buf();
        repeat (64 * 12) @(negedge clk);
        chk("R6", "no new char while low", 16'(full), 16'h0);
        rx = 1'b1;
        repeat (10) @(negedge clk);
        chk("R6", "line low released", 16'(line_low), 16'h0);
        chk("R8", "fe still held", 16'(fe), 16'h1);
        pulse_rd_stat();
        chk("R8", "fe cleared", 16'(fe), 16'h0);
        send(9'h081, 8, 0, 1'b0, 1'b1);
        chk("R6", "recovery char", 16'(data), 16'h0081);
        pulse_rd_buf();
    endtask

    task automatic t_overrun();
        frm_len = 2'b00;
        send(9'h011, 8, 0, 1'b0, 1'b1);
        send(9'h022, 8, 0, 1'b0, 1'b1);
        chk("R7", "ovr set", 16'(ovr), 16'h1);
        chk("R7", "old data kept", 16'(data), 16'h0011);
        chk("R7", "still full", 16'(full), 16'h1);
        pulse_rd_stat();
        chk("R8", "ovr cleared", 16'(ovr), 16'h0);
        pulse_rd_buf();
    endtask

    task automatic t_attn();
        frm_len = 2'b10;
        @(negedge clk) attn_set = 1'b1;
        @(negedge clk) attn_set = 1'b0;
        chk("R9", "attention entered", 16'(attn), 16'h1);
        send(9'h055, 9, 0, 1'b0, 1'b1);
        chk("R9", "ninth-bit-0 dropped", 16'(full), 16'h0);
        chk("R9", "attention kept", 16'(attn), 16'h1);
        send(9'h1AB, 9, 0, 1'b0, 1'b1);
        chk("R9", "address char full", 16'(full), 16'h1);
        chk("R9", "address char data", 16'(data), 16'h00AB);
        chk("R9", "attention left", 16'(attn), 16'h0);
        pulse_rd_buf();
        send(9'h044, 9, 0, 1'b0, 1'b1);
        chk("R9", "normal char after exit", 16'(full), 16'h1);
        chk("R9", "normal char data", 16'(data), 16'h0044);
        pulse_rd_buf();
    endtask

    task automatic t_glitch();
        frm_len = 2'b00;
        @(negedge clk) rx = 1'b0;
        repeat (12) @(negedge clk);
        rx = 1'b1;
        repeat (64 * 12) @(negedge clk);
        chk("R11", "glitch ignored", 16'(full), 16'h0);
        send(9'h096, 8, 0, 1'b0, 1'b1);
        chk("R11", "char after glitch", 16'(data), 16'h0096);
        pulse_rd_buf();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_eight();
        t_seven();
        t_nine();
        t_parity();
        t_framing();
        t_overrun();
        t_attn();
        t_glitch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule